// File: doc/BRIEF.md
# Reprogrammable Two-Digit Combination Lock

This block is a synchronous Moore state machine that guards a door. The user sets a small code on a bank of switches and presses an Enter button once for each digit. The lock opens only when both entered digits equal the two stored digits. A wrong entry is not reported at once: the error indication appears only after the second digit has been entered, so an observer cannot tell which digit was wrong.

When the lock is open, a further press of Enter starts reprogramming. The next two presses capture new first and second digits from the switches, and the lock then shows open again. The block has two synchronous, active-high resets. The state reset returns the sequencer to its idle state and keeps the stored combination. The combination reset restores the factory digits (first 2'b11, second 2'b01) and does not move the sequencer. An 8-bit debug bus shows the current state as a one-hot code.

The Enter input is a level from a button. An internal rising-edge detector turns each press into a single step. Digit width, default digits, debug width and the state-register encoding are parameters.

Top module: `dial_lock_core`

## Requirements
- R1: Each rising edge of `enter_btn` advances the sequencer by exactly one step, however long the button is held. A press that is already high when `rst` is released causes no step until the button has been released and pressed again.
- R2: `open_o` is high only in the opened state, `error_o` only in the rejected state, `prog_first_o` only in the first-digit programming state and `prog_second_o` only in the second-digit programming state. At most one of the four is high at a time.
- R3: From idle, a step with `code_in` equal to the stored first digit goes to the first-accepted state. A step with any other code goes to the first-rejected state.
- R4: From the first-accepted state, a step with `code_in` equal to the stored second digit goes to the opened state. A step with any other code goes to the rejected state, which raises `error_o`.
- R5: From the first-rejected state, any step goes to the rejected state whatever the code. `error_o` stays low until that second step.
- R6: From the opened state, a step goes to first-digit programming. A step there stores `code_in` as the first digit and goes to second-digit programming. A step there stores `code_in` as the second digit and returns to the opened state.
- R7: From the rejected state, a step returns to idle.
- R8: `rst` puts the sequencer in idle on the next clock and leaves the stored digits unchanged.
- R9: `rst_combo` reloads the first digit with 2'b11 and the second digit with 2'b01 on the next clock. It takes priority over a programming store in the same cycle, and on its own it does not change the sequencer state.
- R10: Without a step, the sequencer state and the stored digits hold, whatever `code_in` does.
- R11: `dbg_state_o` is one-hot in bits 6:0, and bit 7 is always zero. The bit for each state is: bit 0 idle, bit 1 first-accepted, bit 2 first-rejected, bit 3 opened, bit 4 rejected, bit 5 first-digit programming, bit 6 second-digit programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the sequencer and edge detector |
| rst_combo | input | 1 | Synchronous active-high reload of the default combination |
| enter_btn | input | 1 | Enter button level |
| code_in | input | DIGIT_W (2) | Digit set on the switches |
| open_o | output | 1 | Lock open |
| error_o | output | 1 | Bad combination entered |
| prog_first_o | output | 1 | Waiting for the new first digit |
| prog_second_o | output | 1 | Waiting for the new second digit |
| dbg_state_o | output | DBG_W (8) | One-hot code of the current state |

## Verification
The assertions assume that `rst` is high during the first clock, so that the state register starts from idle. They also assume that `enter_btn`, `code_in` and both resets change only between clock edges and never in the cycle a property samples them. The bench drives every input on the falling clock edge. It keeps `rst` high from time zero, and it places the combination reset and a programming store in the same cycle on purpose, to check priority. A random phase then mixes button presses, switch changes and occasional resets of both kinds, and the reference model is compared against the outputs on every cycle.

// File: rtl/dial_lock_pkg.sv
package dial_lock_pkg;

   localparam int NUM_STATES = 7;
   localparam int STATE_BITS = 3;

   // Sequencer states. The numeric value is also the debug bit index.
   typedef enum logic [STATE_BITS-1:0] {
      ST_IDLE   = 3'd0,
      ST_ACC1   = 3'd1,
      ST_REJ1   = 3'd2,
      ST_OPEN   = 3'd3,
      ST_REJ2   = 3'd4,
      ST_PROG1  = 3'd5,
      ST_PROG2  = 3'd6
   } lock_state_e;

   function automatic logic [NUM_STATES-1:0] state_onehot(input lock_state_e s);
      return NUM_STATES'(1) << s;
   endfunction

endpackage

// File: rtl/dl_edge_pulse.sv
// Turns a button level into a one-cycle step pulse on its rising edge.
module dl_edge_pulse (
   input  logic clk,
   input  logic rst,
   input  logic level_i,
   output logic pulse_o
);

   logic seen_q;

   // During reset the button counts as already seen, so a held press
   // does not leak through when reset is released.
   always_ff @(posedge clk) begin
      if (rst) seen_q <= 1'b1;
      else     seen_q <= level_i;
   end

   assign pulse_o = level_i & ~seen_q & ~rst;

   // A pulse never lasts two cycles.
   p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
      pulse_o |=> !pulse_o);

endmodule

// File: rtl/dl_digit_store.sv
// Bank of combination digit registers with default reload.
module dl_digit_store #(
   parameter int DIGIT_W    = 2,
   parameter int NUM_DIGITS = 2,
   parameter logic [NUM_DIGITS*DIGIT_W-1:0] DEF_CODE = '0
) (
   input  logic                          clk,
   input  logic                          rst_combo,
   input  logic [NUM_DIGITS-1:0]         load_i,
   input  logic [DIGIT_W-1:0]            code_i,
   output logic [NUM_DIGITS*DIGIT_W-1:0] digits_o
);

   localparam int TOTAL_W = NUM_DIGITS * DIGIT_W;

   if (DIGIT_W < 1) begin : g_bad_width
      $error("dl_digit_store: DIGIT_W must be at least 1");
   end
   if (NUM_DIGITS < 1) begin : g_bad_count
      $error("dl_digit_store: NUM_DIGITS must be at least 1");
   end

   for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
      logic [DIGIT_W-1:0] dig_q;
      always_ff @(posedge clk) begin
         if (rst_combo)      dig_q <= DEF_CODE[g*DIGIT_W +: DIGIT_W];
         else if (load_i[g]) dig_q <= code_i;
      end
      assign digits_o[g*DIGIT_W +: DIGIT_W] = dig_q;
   end

   // Default reload wins over any load.
   p_default_reload_r9: assert property (@(posedge clk)
      rst_combo |=> (digits_o == TOTAL_W'(DEF_CODE)));

   // Digits hold when neither reload nor load is requested.
   p_digits_hold_r10: assert property (@(posedge clk) disable iff (rst_combo)
      (load_i == '0) |=> $stable(digits_o));

endmodule

// File: rtl/dl_seq_fsm.sv
// Entry sequencer: comparators, next-state logic and state register.
module dl_seq_fsm
   import dial_lock_pkg::*;
#(
   parameter int DIGIT_W      = 2,
   parameter bit ONEHOT_STATE = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               step_i,
   input  logic [DIGIT_W-1:0] code_i,
   input  logic [DIGIT_W-1:0] first_i,
   input  logic [DIGIT_W-1:0] second_i,
   output logic               load_first_o,
   output logic               load_second_o,
   output lock_state_e        state_o
);

   lock_state_e cur;
   lock_state_e nxt;
   logic        hit_first;
   logic        hit_second;

   assign hit_first  = (code_i == first_i);
   assign hit_second = (code_i == second_i);

   always_comb begin
      nxt = cur;
      if (step_i) begin
         unique case (cur)
            ST_IDLE:  nxt = hit_first  ? ST_ACC1 : ST_REJ1;
            ST_ACC1:  nxt = hit_second ? ST_OPEN : ST_REJ2;
            ST_REJ1:  nxt = ST_REJ2;
            ST_OPEN:  nxt = ST_PROG1;
            ST_PROG1: nxt = ST_PROG2;
            ST_PROG2: nxt = ST_OPEN;
            ST_REJ2:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
         endcase
      end
   end

   assign load_first_o  = step_i & (cur == ST_PROG1);
   assign load_second_o = step_i & (cur == ST_PROG2);

   if (ONEHOT_STATE) begin : g_onehot
      logic [NUM_STATES-1:0] st_q;
      always_ff @(posedge clk) begin
         if (rst) st_q <= state_onehot(ST_IDLE);
         else     st_q <= state_onehot(nxt);
      end
      // A register that is not one-hot falls back to idle.
      always_comb begin
         cur = ST_IDLE;
         if ($onehot(st_q)) begin
            for (int i = 0; i < NUM_STATES; i++) begin
               if (st_q[i]) cur = lock_state_e'(i[STATE_BITS-1:0]);
            end
         end
      end
   end else begin : g_binary
      logic [STATE_BITS-1:0] st_q;
      always_ff @(posedge clk) begin
         if (rst) st_q <= ST_IDLE;
         else     st_q <= nxt;
      end
      // The spare code falls back to idle.
      always_comb begin
         if (st_q <= STATE_BITS'(ST_PROG2)) cur = lock_state_e'(st_q);
         else                               cur = ST_IDLE;
      end
   end

   assign state_o = cur;

   p_reset_idle_r8: assert property (@(posedge clk)
      rst |=> (cur == ST_IDLE));

   p_hold_without_step_r10: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> (cur == $past(cur)));

   p_rej1_to_rej2_r5: assert property (@(posedge clk) disable iff (rst)
      (step_i && cur == ST_REJ1) |=> (cur == ST_REJ2));

   p_rej2_to_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (step_i && cur == ST_REJ2) |=> (cur == ST_IDLE));

   p_open_to_prog_r6: assert property (@(posedge clk) disable iff (rst)
      (step_i && cur == ST_OPEN) |=> (cur == ST_PROG1));

endmodule

// File: rtl/dial_lock_core.sv
module dial_lock_core
   import dial_lock_pkg::*;
#(
   parameter int                 DIGIT_W      = 2,
   parameter logic [DIGIT_W-1:0] DEF_FIRST    = 2'b11,
   parameter logic [DIGIT_W-1:0] DEF_SECOND   = 2'b01,
   parameter int                 DBG_W        = 8,
   parameter bit                 ONEHOT_STATE = 1'b0
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               rst_combo,
   input  logic               enter_btn,
   input  logic [DIGIT_W-1:0] code_in,
   output logic               open_o,
   output logic               error_o,
   output logic               prog_first_o,
   output logic               prog_second_o,
   output logic [DBG_W-1:0]   dbg_state_o
);

   localparam int NUM_DIGITS = 2;
   localparam int STORE_W    = NUM_DIGITS * DIGIT_W;
   localparam logic [STORE_W-1:0] DEF_CODE = {DEF_SECOND, DEF_FIRST};

   if (DBG_W < NUM_STATES) begin : g_bad_dbg
      $error("dial_lock_core: DBG_W must hold one bit per state");
   end

   logic                  step;
   logic [NUM_DIGITS-1:0] load_vec;
   logic [STORE_W-1:0]    digits;
   lock_state_e           state;
   logic                  load_first;
   logic                  load_second;

   dl_edge_pulse u_edge (
      .clk     (clk),
      .rst     (rst),
      .level_i (enter_btn),
      .pulse_o (step)
   );

   assign load_vec = {load_second, load_first};

   dl_digit_store #(
      .DIGIT_W    (DIGIT_W),
      .NUM_DIGITS (NUM_DIGITS),
      .DEF_CODE   (DEF_CODE)
   ) u_store (
      .clk       (clk),
      .rst_combo (rst_combo),
      .load_i    (load_vec),
      .code_i    (code_in),
      .digits_o  (digits)
   );

   dl_seq_fsm #(
      .DIGIT_W      (DIGIT_W),
      .ONEHOT_STATE (ONEHOT_STATE)
   ) u_fsm (
      .clk           (clk),
      .rst           (rst),
      .step_i        (step),
      .code_i        (code_in),
      .first_i       (digits[0 +: DIGIT_W]),
      .second_i      (digits[DIGIT_W +: DIGIT_W]),
      .load_first_o  (load_first),
      .load_second_o (load_second),
      .state_o       (state)
   );

   // Moore output decode.
   assign open_o        = (state == ST_OPEN);
   assign error_o       = (state == ST_REJ2);
   assign prog_first_o  = (state == ST_PROG1);
   assign prog_second_o = (state == ST_PROG2);
   assign dbg_state_o   = DBG_W'(state_onehot(state));

   p_flags_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
      $onehot0({open_o, error_o, prog_first_o, prog_second_o}));

   p_dbg_onehot_r11: assert property (@(posedge clk) disable iff (rst)
      $onehot(dbg_state_o[NUM_STATES-1:0]) && (dbg_state_o[DBG_W-1:NUM_STATES] == '0));

   p_error_tracks_dbg_r2: assert property (@(posedge clk) disable iff (rst)
      error_o |-> dbg_state_o[4]);

endmodule

// File: tb/sim_dial_lock_core.sv
`timescale 1ns/1ps
module sim_dial_lock_core;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       rst_combo = 1'b1;
   logic       enter_btn = 1'b0;
   logic [1:0] code_in = 2'b00;
   logic       open_o, error_o, prog_first_o, prog_second_o;
   logic [7:0] dbg_state_o;

   int total = 0;
   int bad = 0;
   int cycles = 0;

   // Reference model state: 0 idle, 1 acc1, 2 rej1, 3 open, 4 rej2, 5 prog1, 6 prog2
   int         m_st = 0;
   logic [1:0] m_d1 = 2'b11;
   logic [1:0] m_d2 = 2'b01;
   logic       m_prev = 1'b1;

   always #2.5 clk = ~clk;

   dial_lock_core u0 (
      .clk           (clk),
      .rst           (rst),
      .rst_combo     (rst_combo),
      .enter_btn     (enter_btn),
      .code_in       (code_in),
      .open_o        (open_o),
      .error_o       (error_o),
      .prog_first_o  (prog_first_o),
      .prog_second_o (prog_second_o),
      .dbg_state_o   (dbg_state_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural model, updated on each rising edge from stable inputs.
   always @(posedge clk) begin
      logic step;
      int   ns;
      step = enter_btn && !m_prev && !rst;
      ns = m_st;
      if (step) begin
         case (m_st)
            0: ns = (code_in == m_d1) ? 1 : 2;
            1: ns = (code_in == m_d2) ? 3 : 4;
            2: ns = 4;
            3: ns = 5;
            4: ns = 0;
            5: ns = 6;
            default: ns = 3;
         endcase
      end
      if (rst_combo) begin
         m_d1 = 2'b11;
         m_d2 = 2'b01;
      end else if (step && m_st == 5) m_d1 = code_in;
      else if (step && m_st == 6)     m_d2 = code_in;
      m_st   = rst ? 0 : ns;
      m_prev = rst ? 1'b1 : enter_btn;
   end

   // Cycle-by-cycle comparison against the model.
   always @(negedge clk) begin
      cycles++;
      if (cycles > 3) begin
         chk("R11 dbg", int'(dbg_state_o), 1 << m_st);
         chk("R2 open", int'(open_o), int'(m_st == 3));
         chk("R2 error", int'(error_o), int'(m_st == 4));
         chk("R2 prog1", int'(prog_first_o), int'(m_st == 5));
         chk("R2 prog2", int'(prog_second_o), int'(m_st == 6));
      end
      if (cycles > 100000) begin
         bad++;
         $display("FAIL watchdog act=%0d exp=done", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic press(input logic [1:0] c);
      @(negedge clk);
      code_in = c;
      enter_btn = 1'b1;
      @(negedge clk);
      enter_btn = 1'b0;
      @(negedge clk);
   endtask

   task automatic pulse_rst();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      rst_combo = 1'b0;
      @(negedge clk);
      chk("R8 reset idle", int'(dbg_state_o), 1);
      chk("R2 reset open", int'(open_o), 0);

      // Default combination opens.
      press(2'b11);
      chk("R3 first hit", int'(dbg_state_o), 2);
      press(2'b01);
      chk("R4 second hit opens", int'(open_o), 1);

      // Reprogram to 00, 10.
      press(2'b00);
      chk("R6 prog first", int'(prog_first_o), 1);
      press(2'b00);
      chk("R6 prog second", int'(prog_second_o), 1);
      press(2'b10);
      chk("R6 back open", int'(open_o), 1);

      // State reset keeps the new combination.
      pulse_rst();
      chk("R8 idle after rst", int'(dbg_state_o), 1);
      press(2'b00);
      press(2'b10);
      chk("R8 combo kept", int'(open_o), 1);

      // Wrong first digit: error deferred.
      pulse_rst();
      press(2'b01);
      chk("R3 first miss", int'(dbg_state_o), 4);
      chk("R5 no early error", int'(error_o), 0);
      press(2'b10);
      chk("R5 error after second", int'(error_o), 1);
      press(2'b00);
      chk("R7 back to idle", int'(dbg_state_o), 1);

      // Right first, wrong second.
      press(2'b00);
      press(2'b11);
      chk("R4 second miss", int'(error_o), 1);
      press(2'b00);

      // Switches move without Enter.
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         code_in = 2'(i);
      end
      @(negedge clk);
      chk("R10 hold idle", int'(dbg_state_o), 1);

      // Long press gives one step.
      @(negedge clk);
      code_in = 2'b00;
      enter_btn = 1'b1;
      repeat (6) @(negedge clk);
      enter_btn = 1'b0;
      @(negedge clk);
      chk("R1 held one step", int'(dbg_state_o), 2);

      // Combination reload alone: state unchanged, default active.
      @(negedge clk);
      rst_combo = 1'b1;
      @(negedge clk);
      rst_combo = 1'b0;
      @(negedge clk);
      chk("R9 state kept", int'(dbg_state_o), 2);
      press(2'b01);
      chk("R9 default second", int'(open_o), 1);

      // Reload in the same cycle as the second store.
      press(2'b00);
      press(2'b10);
      @(negedge clk);
      code_in = 2'b00;
      enter_btn = 1'b1;
      rst_combo = 1'b1;
      @(negedge clk);
      enter_btn = 1'b0;
      rst_combo = 1'b0;
      @(negedge clk);
      chk("R9 store step still taken", int'(open_o), 1);
      pulse_rst();
      press(2'b11);
      press(2'b01);
      chk("R9 reload wins over store", int'(open_o), 1);

      // Press held across reset release.
      @(negedge clk);
      enter_btn = 1'b1;
      code_in = 2'b11;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 held through reset", int'(dbg_state_o), 1);
      enter_btn = 1'b0;
      @(negedge clk);

      // Random phase, checked by the model every cycle.
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         enter_btn = ($urandom % 3) == 0;
         code_in   = 2'($urandom);
         rst       = ($urandom % 61) == 0;
         rst_combo = ($urandom % 47) == 0;
      end
      @(negedge clk);
      rst = 1'b0;
      rst_combo = 1'b0;
      enter_btn = 1'b0;
      repeat (3) @(negedge clk);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule